// File: doc/BRIEF.md
# Programmable Asynchronous Memory Controller

This block turns single requests from an internal port into bus cycles for static-style external devices: asynchronous SRAM, NOR-type flash and the command, address and data cycles of a NAND flash. It serves four chip-select spaces. Each space has its own configuration inputs: read and write timings, a turnaround length, the chip-select style, an extended-wait enable with its polarity, the data width, and a NAND flag. Every timing value is stored as its cycle count minus one.

An access runs in the order setup, strobe, hold. The state machine has five states, `ST_IDLE`, `ST_TURN`, `ST_SETUP`, `ST_STROBE` and `ST_HOLD`, and these transitions:

- *accept*: `ST_IDLE` to `ST_TURN` when a turnaround is needed, otherwise `ST_IDLE` to `ST_SETUP`.
- *turn-done*: `ST_TURN` to `ST_SETUP`.
- *setup-done*: `ST_SETUP` to `ST_STROBE`.
- *strobe-done*: `ST_STROBE` to `ST_HOLD`. This happens when the strobe count has expired and the wait is not holding the strobe. It also happens when the wait has held the strobe past the timeout limit.
- *hold-done*: `ST_HOLD` to `ST_IDLE`.

A request is accepted only in `ST_IDLE`. This leaves at least one idle cycle between accesses.

The wait input of each space passes through a two-flop synchronizer. When extended wait is enabled, the synchronized wait can hold the strobe open past its programmed end. A one-cycle `done_o` pulse returns read data. The same pulse carries `tmo_o` when the access was cut short by the timeout.

Top module: `amc_ctrl`

## Requirements
- R1: For a read in normal mode, chip select is low for (rs+1)+(rst+1)+(rh+1) cycles. Output enable is low for the last rst+1 of the (rst+1) strobe cycles only. Here rs, rst and rh are the selected space's read setup, strobe and hold fields.
- R2: A write uses the write fields. Write enable is low for wst+1 cycles. During the access `mem_dout` carries the data, `mem_doe` is 1 and `mem_rnw` is 0. `mem_rnw` is 1 when no write is in progress.
- R3: Only the chip-select bit of the requested space (bit index = `req_cs`) goes low, and at most one bit is low at a time. Each space's fields apply only to that space.
- R4: In select-strobe mode (`cfg_sel_strobe` bit = 1), chip select is low only during the strobe cycles. In normal mode it is low from the first setup cycle to the last hold cycle.
- R5: Before setup, ta+1 idle cycles are inserted when the new request's direction differs from the previous access, or when its space differs. ta is taken from the new request's space. Back-to-back accesses with the same direction to the same space get no gap. The first access after reset gets no gap.
- R6: In 16-bit mode (`cfg_wide` = 1), `mem_addr` = `req_addr` >> 1, `mem_be_n` = ~`req_be`, and read data is all 16 bits of `mem_din`. In 8-bit mode:
  - `mem_addr` = `req_addr` and `mem_be_n` = 2'b10.
  - Write data goes on bits [7:0]. It is `req_wdata[15:8]` when `req_addr[0]` = 1, otherwise `req_wdata[7:0]`. Bits [15:8] are 0.
  - Read data is {8'h00, `mem_din[7:0]`}.
- R7: With extended wait enabled, the strobe continues while the synchronized wait is active. Wait is active when the input equals the space's `cfg_wait_pol` bit. The strobe ends in the second cycle after the input goes inactive. With extended wait disabled, the wait input has no effect.
- R8: Once the strobe count has expired, if wait holds the strobe for `tmo_max`+1 further decisions, the strobe ends. The strobe then lasts rst+1+`tmo_max` cycles, and `tmo_o` is 1 together with `done_o`.
- R9: In NAND mode (`cfg_nand` bit = 1), `mem_addr` is zero except bit 1 (command latch) = `req_addr[1]` and bit 0 (address latch) = `req_addr[0]`. 8-bit write data is then always `req_wdata[7:0]`.
- R10: `done_o` is a one-cycle pulse in the cycle after the last strobe cycle. `rdata_o` then holds the data sampled in that last strobe cycle.
- R11: After reset, all chip selects, `mem_oe_n` and `mem_we_n` are high, `mem_rnw` is 1, `req_ready` is 1 and `done_o` is 0.
- R12: Output enable and write enable are never low together, and neither is low outside the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request accepted when high with valid |
| req_we | input | 1 | 1 = write |
| req_cs | input | 2 | target space |
| req_addr | input | 23 | byte address |
| req_wdata | input | 16 | write data |
| req_be | input | 2 | byte enables |
| done_o | output | 1 | access completion pulse |
| tmo_o | output | 1 | wait timeout, with done |
| rdata_o | output | 16 | read data |
| tmo_max | input | 8 | wait timeout limit |
| cfg_r_setup | input | 16 | per-space read setup minus one (4 bits each) |
| cfg_r_strobe | input | 24 | per-space read strobe minus one (6 bits each) |
| cfg_r_hold | input | 12 | per-space read hold minus one (3 bits each) |
| cfg_w_setup | input | 16 | per-space write setup minus one |
| cfg_w_strobe | input | 24 | per-space write strobe minus one |
| cfg_w_hold | input | 12 | per-space write hold minus one |
| cfg_turn | input | 8 | per-space turnaround minus one (2 bits each) |
| cfg_sel_strobe | input | 4 | per-space select-strobe mode |
| cfg_ext_wait | input | 4 | per-space extended wait enable |
| cfg_wait_pol | input | 4 | per-space wait active level |
| cfg_wide | input | 4 | per-space 16-bit data path |
| cfg_nand | input | 4 | per-space NAND mode |
| mem_cs_n | output | 4 | chip selects, active low |
| mem_oe_n | output | 1 | output enable, active low |
| mem_we_n | output | 1 | write enable, active low |
| mem_rnw | output | 1 | direction, 1 = read |
| mem_addr | output | 23 | external address |
| mem_be_n | output | 2 | byte lane enables, active low |
| mem_dout | output | 16 | write data to device |
| mem_doe | output | 1 | data bus drive enable |
| mem_din | input | 16 | read data from device |
| mem_wait | input | 4 | per-space wait inputs |

## Verification
The assertions watch every cycle for the following:
- output enable and write enable never active together;
- no strobe without a chip select;
- at most one chip select at a time;
- a quiet bus whenever the port is ready;
- a done pulse that never lasts two cycles;
- a timeout flag that never appears without done.

Only the directed scenarios can show the exact phase lengths, the turnaround gap decision, the byte-lane and NAND address formatting, and the cycle in which a released wait ends the strobe.

// File: rtl/amc_pkg.sv
package amc_pkg;
    localparam int BUS_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } amc_state_e;
endpackage

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
    parameter int NCS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCS-1:0] wait_raw,
    input  logic [NCS-1:0] wait_pol,
    output logic [NCS-1:0] wait_act
);
    generate
        for (genvar g = 0; g < NCS; g++) begin : g_sync
            logic s1, s2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1 <= ~wait_pol[g];
                    s2 <= ~wait_pol[g];
                end else begin
                    s1 <= wait_raw[g];
                    s2 <= s1;
                end
            end
            assign wait_act[g] = (s2 == wait_pol[g]);
        end
    endgenerate
endmodule

// File: rtl/amc_cfg_sel.sv
module amc_cfg_sel #(
    parameter int NCS = 4,
    parameter int SW  = 4,
    parameter int STW = 6,
    parameter int HW  = 3,
    parameter int TW  = 2,
    localparam int CSW = $clog2(NCS)
) (
    input  logic [CSW-1:0]     sel_cs,
    input  logic               sel_we,
    input  logic [NCS*SW-1:0]  r_setup,
    input  logic [NCS*STW-1:0] r_strobe,
    input  logic [NCS*HW-1:0]  r_hold,
    input  logic [NCS*SW-1:0]  w_setup,
    input  logic [NCS*STW-1:0] w_strobe,
    input  logic [NCS*HW-1:0]  w_hold,
    input  logic [NCS*TW-1:0]  turn,
    output logic [SW-1:0]      o_setup,
    output logic [STW-1:0]     o_strobe,
    output logic [HW-1:0]      o_hold,
    output logic [TW-1:0]      o_turn
);
    logic [SW-1:0]  rs, ws;
    logic [STW-1:0] rst, wst;
    logic [HW-1:0]  rh, wh;

    always_comb begin
        rs  = r_setup[sel_cs*SW +: SW];
        ws  = w_setup[sel_cs*SW +: SW];
        rst = r_strobe[sel_cs*STW +: STW];
        wst = w_strobe[sel_cs*STW +: STW];
        rh  = r_hold[sel_cs*HW +: HW];
        wh  = w_hold[sel_cs*HW +: HW];
        o_turn   = turn[sel_cs*TW +: TW];
        o_setup  = sel_we ? ws  : rs;
        o_strobe = sel_we ? wst : rst;
        o_hold   = sel_we ? wh  : rh;
    end
endmodule

// File: rtl/amc_lane.sv
module amc_lane #(
    parameter int AW = 23,
    localparam int BW = amc_pkg::BUS_W
) (
    input  logic          wide,
    input  logic          nand_mode,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    input  logic [1:0]    be,
    input  logic [BW-1:0] din,
    output logic [AW-1:0] o_addr,
    output logic [1:0]    o_be_n,
    output logic [BW-1:0] o_dout,
    output logic [BW-1:0] o_rdata
);
    logic [7:0] byte_sel;

    always_comb begin
        byte_sel = (addr[0] && !nand_mode) ? wdata[15:8] : wdata[7:0];
        if (nand_mode)
            o_addr = {{(AW-2){1'b0}}, addr[1:0]};
        else if (wide)
            o_addr = {1'b0, addr[AW-1:1]};
        else
            o_addr = addr;
        o_be_n  = wide ? ~be : 2'b10;
        o_dout  = wide ? wdata : {8'h00, byte_sel};
        o_rdata = wide ? din : {8'h00, din[7:0]};
    end
endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl #(
    parameter int NCS = 4,
    parameter int AW  = 23,
    parameter int SW  = 4,
    parameter int STW = 6,
    parameter int HW  = 3,
    parameter int TW  = 2,
    parameter int MWW = 8,
    localparam int CSW = $clog2(NCS),
    localparam int BW  = amc_pkg::BUS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [CSW-1:0]     req_cs,
    input  logic [AW-1:0]      req_addr,
    input  logic [BW-1:0]      req_wdata,
    input  logic [1:0]         req_be,
    output logic               done_o,
    output logic               tmo_o,
    output logic [BW-1:0]      rdata_o,
    input  logic [MWW-1:0]     tmo_max,
    input  logic [NCS*SW-1:0]  cfg_r_setup,
    input  logic [NCS*STW-1:0] cfg_r_strobe,
    input  logic [NCS*HW-1:0]  cfg_r_hold,
    input  logic [NCS*SW-1:0]  cfg_w_setup,
    input  logic [NCS*STW-1:0] cfg_w_strobe,
    input  logic [NCS*HW-1:0]  cfg_w_hold,
    input  logic [NCS*TW-1:0]  cfg_turn,
    input  logic [NCS-1:0]     cfg_sel_strobe,
    input  logic [NCS-1:0]     cfg_ext_wait,
    input  logic [NCS-1:0]     cfg_wait_pol,
    input  logic [NCS-1:0]     cfg_wide,
    input  logic [NCS-1:0]     cfg_nand,
    output logic [NCS-1:0]     mem_cs_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic               mem_rnw,
    output logic [AW-1:0]      mem_addr,
    output logic [1:0]         mem_be_n,
    output logic [BW-1:0]      mem_dout,
    output logic               mem_doe,
    input  logic [BW-1:0]      mem_din,
    input  logic [NCS-1:0]     mem_wait
);
    import amc_pkg::*;

    localparam int CW1 = (SW > STW) ? SW : STW;
    localparam int CW2 = (HW > TW) ? HW : TW;
    localparam int CW  = (CW1 > CW2) ? CW1 : CW2;

    amc_state_e state, nxt;

    logic [CW-1:0]  cnt;
    logic [MWW-1:0] wcnt;
    logic           lat_we, prev_valid, prev_we;
    logic [CSW-1:0] lat_cs, prev_cs;
    logic [AW-1:0]  lat_addr;
    logic [BW-1:0]  lat_wdata;
    logic [1:0]     lat_be;

    logic [CSW-1:0] sel_cs;
    logic           sel_we;
    logic [SW-1:0]  t_setup;
    logic [STW-1:0] t_strobe;
    logic [HW-1:0]  t_hold;
    logic [TW-1:0]  t_turn;
    logic [NCS-1:0] wait_act;
    logic [BW-1:0]  rfmt;

    logic need_turn, cnt_zero, wait_hold, tmo_hit, strobe_end, active, cs_on;

    assign sel_cs = (state == ST_IDLE) ? req_cs : lat_cs;
    assign sel_we = (state == ST_IDLE) ? req_we : lat_we;

    amc_cfg_sel #(.NCS(NCS), .SW(SW), .STW(STW), .HW(HW), .TW(TW)) u_cfg (
        .sel_cs  (sel_cs),
        .sel_we  (sel_we),
        .r_setup (cfg_r_setup),
        .r_strobe(cfg_r_strobe),
        .r_hold  (cfg_r_hold),
        .w_setup (cfg_w_setup),
        .w_strobe(cfg_w_strobe),
        .w_hold  (cfg_w_hold),
        .turn    (cfg_turn),
        .o_setup (t_setup),
        .o_strobe(t_strobe),
        .o_hold  (t_hold),
        .o_turn  (t_turn)
    );

    amc_wait_sync #(.NCS(NCS)) u_wsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_raw(mem_wait),
        .wait_pol(cfg_wait_pol),
        .wait_act(wait_act)
    );

    amc_lane #(.AW(AW)) u_lane (
        .wide     (cfg_wide[lat_cs]),
        .nand_mode(cfg_nand[lat_cs]),
        .addr     (lat_addr),
        .wdata    (lat_wdata),
        .be       (lat_be),
        .din      (mem_din),
        .o_addr   (mem_addr),
        .o_be_n   (mem_be_n),
        .o_dout   (mem_dout),
        .o_rdata  (rfmt)
    );

    assign need_turn  = prev_valid && ((prev_we != req_we) || (prev_cs != req_cs));
    assign cnt_zero   = (cnt == '0);
    assign wait_hold  = cfg_ext_wait[lat_cs] && wait_act[lat_cs];
    assign tmo_hit    = wait_hold && (wcnt == tmo_max);
    assign strobe_end = cnt_zero && (!wait_hold || tmo_hit);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = need_turn ? ST_TURN : ST_SETUP;
            ST_TURN:   if (cnt_zero) nxt = ST_SETUP;
            ST_SETUP:  if (cnt_zero) nxt = ST_STROBE;
            ST_STROBE: if (strobe_end) nxt = ST_HOLD;
            ST_HOLD:   if (cnt_zero) nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // phase counters and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            wcnt       <= '0;
            lat_we     <= 1'b0;
            lat_cs     <= '0;
            lat_addr   <= '0;
            lat_wdata  <= '0;
            lat_be     <= '0;
            prev_valid <= 1'b0;
            prev_we    <= 1'b0;
            prev_cs    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    cnt        <= need_turn ? CW'(t_turn) : CW'(t_setup);
                    lat_we     <= req_we;
                    lat_cs     <= req_cs;
                    lat_addr   <= req_addr;
                    lat_wdata  <= req_wdata;
                    lat_be     <= req_be;
                    prev_valid <= 1'b1;
                    prev_we    <= req_we;
                    prev_cs    <= req_cs;
                end
                ST_TURN:  cnt <= cnt_zero ? CW'(t_setup) : cnt - 1'b1;
                ST_SETUP: begin
                    cnt  <= cnt_zero ? CW'(t_strobe) : cnt - 1'b1;
                    wcnt <= '0;
                end
                ST_STROBE: begin
                    if (!cnt_zero)       cnt  <= cnt - 1'b1;
                    else if (strobe_end) cnt  <= CW'(t_hold);
                    if (cnt_zero && wait_hold && !tmo_hit) wcnt <= wcnt + 1'b1;
                end
                ST_HOLD: if (!cnt_zero) cnt <= cnt - 1'b1;
            endcase
        end
    end

    // completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            tmo_o   <= 1'b0;
            rdata_o <= '0;
        end else if (state == ST_STROBE && strobe_end) begin
            done_o <= 1'b1;
            tmo_o  <= tmo_hit;
            if (!lat_we) rdata_o <= rfmt;
        end else begin
            done_o <= 1'b0;
            tmo_o  <= 1'b0;
        end
    end

    // bus outputs
    always_comb begin
        active    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        cs_on     = cfg_sel_strobe[lat_cs] ? (state == ST_STROBE) : active;
        mem_cs_n  = ~(cs_on ? (NCS'(1) << lat_cs) : '0);
        mem_oe_n  = !((state == ST_STROBE) && !lat_we);
        mem_we_n  = !((state == ST_STROBE) && lat_we);
        mem_rnw   = !(active && lat_we);
        mem_doe   = active && lat_we;
        req_ready = (state == ST_IDLE);
    end

    // checks
    assert_cmd_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));
    assert_strobe_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != {NCS{1'b1}}));
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n == {NCS{1'b1}} && mem_oe_n && mem_we_n && mem_rnw));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_tmo_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> done_o);
    assert_done_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state == ST_STROBE));
endmodule

// File: tb/amc_ctrl_tb.sv
module amc_ctrl_tb;
    localparam int NCS = 4, AW = 23, SW = 4, STW = 6, HW = 3, TW = 2, MWW = 8;

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic           req_valid = 0, req_we = 0;
    logic           req_ready;
    logic [1:0]     req_cs = 0, req_be = 2'b11;
    logic [AW-1:0]  req_addr = 0;
    logic [15:0]    req_wdata = 0;
    logic           done_o, tmo_o;
    logic [15:0]    rdata_o;
    logic [MWW-1:0] tmo_max = 8'd20;
    logic [NCS*SW-1:0]  r_setup = 0, w_setup = 0;
    logic [NCS*STW-1:0] r_strobe = 0, w_strobe = 0;
    logic [NCS*HW-1:0]  r_hold = 0, w_hold = 0;
    logic [NCS*TW-1:0]  turn = 0;
    logic [NCS-1:0] sel_strobe = 0, ext_wait = 0, wait_pol = 4'hF, wide = 0, nandm = 0;
    logic [NCS-1:0] mem_cs_n;
    logic           mem_oe_n, mem_we_n, mem_rnw, mem_doe;
    logic [AW-1:0]  mem_addr;
    logic [1:0]     mem_be_n;
    logic [15:0]    mem_dout, mem_din;
    logic [NCS-1:0] mem_wait = 4'h0;

    assign mem_din = {~mem_addr[7:0], mem_addr[7:0]};

    amc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .done_o(done_o), .tmo_o(tmo_o), .rdata_o(rdata_o),
        .tmo_max(tmo_max), .cfg_r_setup(r_setup), .cfg_r_strobe(r_strobe),
        .cfg_r_hold(r_hold), .cfg_w_setup(w_setup), .cfg_w_strobe(w_strobe),
        .cfg_w_hold(w_hold), .cfg_turn(turn), .cfg_sel_strobe(sel_strobe),
        .cfg_ext_wait(ext_wait), .cfg_wait_pol(wait_pol), .cfg_wide(wide),
        .cfg_nand(nandm), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_rnw(mem_rnw), .mem_addr(mem_addr),
        .mem_be_n(mem_be_n), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din), .mem_wait(mem_wait)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // results of one access
    int g_pre, g_cs, g_cs_nostr, g_oe, g_we, g_done_idx, g_last_str, g_tmo, g_badcs, g_wrbad;
    logic [15:0]   g_rdata, g_dout;
    logic [AW-1:0] g_addr;
    logic [1:0]    g_ben;
    int rel_after = 0, rel_idx = 0;
    logic rel_lvl = 0;

    task automatic set_space(input int s, input int rs, input int rst, input int rh,
                             input int ws, input int wst, input int wh, input int ta,
                             input bit ss, input bit wd);
        r_setup[s*SW +: SW]    = SW'(rs);
        r_strobe[s*STW +: STW] = STW'(rst);
        r_hold[s*HW +: HW]     = HW'(rh);
        w_setup[s*SW +: SW]    = SW'(ws);
        w_strobe[s*STW +: STW] = STW'(wst);
        w_hold[s*HW +: HW]     = HW'(wh);
        turn[s*TW +: TW]       = TW'(ta);
        sel_strobe[s] = ss;
        wide[s]       = wd;
    endtask

    task automatic access(input int cs, input bit we, input logic [AW-1:0] addr,
                          input logic [15:0] wd, input logic [1:0] be);
        bit seen_cs = 0;
        do @(negedge clk); while (!req_ready);
        req_valid = 1; req_cs = 2'(cs); req_we = we; req_addr = addr;
        req_wdata = wd; req_be = be;
        @(posedge clk);
        g_pre = 0; g_cs = 0; g_cs_nostr = 0; g_oe = 0; g_we = 0; g_done_idx = -1;
        g_last_str = -1; g_tmo = 0; g_badcs = 0; g_wrbad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            req_valid = 0;
            if (req_ready) break;
            if (mem_cs_n != 4'hF) begin
                seen_cs = 1; g_cs++;
                if (mem_cs_n != ~(4'b1 << cs)) g_badcs++;
                if (mem_oe_n && mem_we_n) g_cs_nostr++;
            end else if (!seen_cs) g_pre++;
            if (!mem_oe_n) begin g_oe++; g_last_str = i; g_addr = mem_addr; end
            if (!mem_we_n) begin
                g_we++; g_last_str = i; g_addr = mem_addr; g_dout = mem_dout; g_ben = mem_be_n;
                if (mem_rnw || !mem_doe) g_wrbad++;
            end
            if (done_o) begin g_done_idx = i; g_rdata = rdata_o; g_tmo = tmo_o; end
            if (rel_after > 0 && g_oe == rel_after) begin
                mem_wait[rel_idx] = rel_lvl; rel_after = 0;
            end
        end
    endtask

    task automatic t_reset;
        chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n, "R11 bus idle", mem_cs_n, 4'hF);
        chk(mem_rnw && req_ready && !done_o, "R11 ready/rnw/done", {mem_rnw, req_ready, done_o}, 3'b110);
    endtask

    task automatic t_read16;
        access(0, 0, 23'h100, 0, 2'b11);
        chk(g_pre == 0, "R5 no gap first access", g_pre, 0);
        chk(g_cs == 7, "R1 cs low cycles", g_cs, 7);
        chk(g_oe == 3, "R1 oe low cycles", g_oe, 3);
        chk(g_cs - g_cs_nostr == g_oe, "R12 oe only in strobe", g_cs - g_cs_nostr, g_oe);
        chk(g_addr == 23'h80, "R6 word address", g_addr, 23'h80);
        chk(g_badcs == 0, "R3 cs bit", g_badcs, 0);
        chk(g_done_idx == g_last_str + 1, "R10 done timing", g_done_idx, g_last_str + 1);
        chk(g_rdata == 16'h7F80, "R10 R6 read data", g_rdata, 16'h7F80);
        access(0, 0, 23'h102, 0, 2'b11);
        chk(g_pre == 0, "R5 same dir same space no gap", g_pre, 0);
    endtask

    task automatic t_write16;
        access(0, 1, 23'h204, 16'hA55A, 2'b01);
        chk(g_pre == 2, "R5 read->write gap", g_pre, 2);
        chk(g_we == 2 && g_oe == 0, "R2 we low cycles", g_we, 2);
        chk(g_cs == 6, "R2 write phases", g_cs, 6);
        chk(g_dout == 16'hA55A && g_wrbad == 0, "R2 write data/rnw", g_dout, 16'hA55A);
        chk(g_ben == 2'b10, "R6 byte enables", g_ben, 2'b10);
        chk(g_done_idx == g_last_str + 1, "R10 write done", g_done_idx, g_last_str + 1);
        @(negedge clk);
        chk(mem_rnw, "R2 rnw idle", mem_rnw, 1);
    endtask

    task automatic t_sel_strobe;
        access(1, 0, 23'h10, 0, 2'b11);
        chk(g_pre == 6, "R5 R4 gap+setup with cs high", g_pre, 6);
        chk(g_cs == 2 && g_cs_nostr == 0, "R4 cs only in strobe", g_cs, 2);
        chk(g_badcs == 0, "R3 space 1 cs", g_badcs, 0);
    endtask

    task automatic t_bytes;
        access(2, 1, 23'h33, 16'hBEEF, 2'b11);
        chk(g_pre == 1, "R5 space change gap", g_pre, 1);
        chk(g_cs == 3, "R3 space 2 own timing", g_cs, 3);
        chk(g_dout == 16'h00BE, "R6 odd byte lane", g_dout, 16'h00BE);
        chk(g_addr == 23'h33 && g_ben == 2'b10, "R6 byte addr", g_addr, 23'h33);
        access(2, 0, 23'h44, 0, 2'b11);
        chk(g_rdata == 16'h0044, "R6 8-bit read", g_rdata, 16'h0044);
    endtask

    task automatic t_nand;
        nandm[2] = 1;
        access(2, 1, 23'h12346, 16'h3377, 2'b11);
        chk(g_addr == 23'h2, "R9 command latch", g_addr, 2);
        chk(g_dout == 16'h0077, "R9 nand data lane", g_dout, 16'h0077);
        access(2, 1, 23'h12345, 16'h3377, 2'b11);
        chk(g_addr == 23'h1, "R9 address latch", g_addr, 1);
        nandm[2] = 0;
    endtask

    task automatic t_wait;
        // space 3: active-low wait
        mem_wait[3] = 1'b1;
        repeat (3) @(negedge clk);
        access(3, 0, 23'h8, 0, 2'b11);
        chk(g_oe == 2, "R7 inactive wait", g_oe, 2);
        mem_wait[3] = 1'b0;
        repeat (3) @(negedge clk);
        rel_after = 5; rel_idx = 3; rel_lvl = 1'b1;
        access(3, 0, 23'h8, 0, 2'b11);
        chk(g_oe == 7, "R7 stretched strobe", g_oe, 7);
        chk(g_tmo == 0 && g_done_idx == g_last_str + 1, "R7 done no timeout", g_tmo, 0);
        // wait ignored when disabled on space 0 (active-high, held high)
        mem_wait[0] = 1'b1;
        repeat (3) @(negedge clk);
        access(0, 0, 23'h100, 0, 2'b11);
        chk(g_oe == 3, "R7 disabled wait ignored", g_oe, 3);
        mem_wait[0] = 1'b0;
    endtask

    task automatic t_timeout;
        tmo_max = 8'd4;
        mem_wait[3] = 1'b0;
        repeat (3) @(negedge clk);
        access(3, 0, 23'h8, 0, 2'b11);
        chk(g_oe == 6, "R8 timeout strobe length", g_oe, 6);
        chk(g_tmo == 1, "R8 timeout flag", g_tmo, 1);
        mem_wait[3] = 1'b1;
        tmo_max = 8'd20;
    endtask

    initial begin
        set_space(0, 1, 2, 1, 0, 1, 2, 1, 0, 1);
        set_space(1, 2, 1, 0, 1, 0, 0, 2, 1, 1);
        set_space(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        set_space(3, 0, 1, 0, 0, 0, 0, 0, 0, 1);
        ext_wait = 4'b1000;
        wait_pol = 4'b0111;
        mem_wait = 4'b1000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_read16();
        t_write16();
        t_sel_strobe();
        t_bytes();
        t_nand();
        t_wait();
        t_timeout();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule